// File: doc/BRIEF.md
# Power Mode Clock Gating Controller

This controller sits beside a small processor subsystem. It keeps track of the active low-power mode and drives the clock enables for two groups: the core and memory clocks, and the peripheral clocks. The peripheral group has one enable for each timer channel and one for the serial port. Strobes from the WAIT and STOP instructions move the block out of Run. Interrupts, a low-voltage interrupt and a debug-entry request from the test port bring it back. Each group of clocks stays on or goes off according to the mode. In Stop, a peripheral can keep its clock and act as a wake source if its stop-keep bit is set.

A small configuration register holds the stop-keep bits and a clock-ladder step. Software moves the step one rung at a time through five settings. In order, these switch to the slow relaxation clock, power down the PLL, put the oscillator in standby, and put the large regulator in standby. With all four in place the part is in Standby. Standby stays in force through any Wait or Stop entered from it. One more rung powers down the oscillator, and from there only a hard reset brings the part back. A PLL lock counter with a programmable terminal count, together with a lock-status input, gates the return to the PLL clock. The analog parts are represented only by the control outputs and the lock input.

Top module: `pmc_ctrl`

## Requirements
- R1: While `rst_n` is low, and after any reset, `mode_o` is Run (encoding 0). `core_clk_en` and every bit of `per_clk_en` are 1, the ladder step is 0 so all five ladder outputs are 0, and the stop-keep bits are 0.
- R2: A `wait_stb` in Run puts the block in Wait (encoding 1) at the next edge. In Wait `core_clk_en` is 0 and every `per_clk_en` bit is 1.
- R3: In Wait, any bit of `per_irq`, `lvi_irq` or `dbg_req` returns the block to Run at the next edge.
- R4: A `stop_stb` in Run puts the block in Stop (encoding 2) at the next edge. In Stop `core_clk_en` is 0 and `per_clk_en` equals the stop-keep bits. Bit i is timer channel i, and the top bit is the serial port. When both strobes arrive in the same cycle, Stop wins.
- R5: In Stop, a `per_irq` bit wakes the block to Run only when its stop-keep bit is set. `lvi_irq` and `dbg_req` always wake it. Any other interrupt leaves the block in Stop.
- R6: A configuration write in Run always loads the stop-keep bits. It changes the ladder step only when the new value is within one of the current step and no greater than 5; other step values are ignored. Step n≥1 raises `relax_sel_o` (n≥1), `pll_pd_o` (n≥2), `osc_stby_o` (n≥3) and `reg_stby_o` (n≥4). `standby_o` is 1 exactly at step 4.
- R7: `clk_sel_pll` is 1 only when all three hold: the step is 0, the lock counter has counted `lock_tc` edges since the PLL was last powered (step ≤1), and `pll_locked` is 1. `hs_per_clk_en` equals `clk_sel_pll` while in Run or Wait.
- R8: Configuration writes are ignored outside Run, so Standby stays in force throughout a Wait or Stop entered from it.
- R9: A write of step 5 at step 4 puts the block in Power-Down (encoding 3) with all clock enables 0 and `osc_pd_o` 1. Interrupts, debug requests, strobes and the soft and watchdog resets have no effect there; only `rst_n` exits.
- R10: `soft_rst` or `wdog_rst` in Run, Wait or Stop restores the reset state of R1 at the next edge.
- R11: `wait_stb` and `stop_stb` are ignored outside Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Power-on or external reset, active low |
| soft_rst | input | 1 | Software reset request |
| wdog_rst | input | 1 | Watchdog reset request |
| wait_stb | input | 1 | WAIT instruction strobe |
| stop_stb | input | 1 | STOP instruction strobe |
| per_irq | input | NPER | Peripheral interrupts, timers low, serial port on top |
| lvi_irq | input | 1 | Low-voltage interrupt |
| dbg_req | input | 1 | Debug-entry request from the test port |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_step | input | 3 | Requested clock-ladder step |
| cfg_stop_keep | input | NPER | Stop-keep bits to load |
| lock_tc | input | LOCK_W | PLL lock terminal count |
| pll_locked | input | 1 | PLL lock status |
| mode_o | output | 2 | 0 Run, 1 Wait, 2 Stop, 3 Power-Down |
| core_clk_en | output | 1 | Core and memory clock enable |
| per_clk_en | output | NPER | Per-peripheral clock enables |
| hs_per_clk_en | output | 1 | High-speed peripheral clock enable |
| clk_sel_pll | output | 1 | System clock taken from the PLL |
| relax_sel_o | output | 1 | Relaxation clock source selected |
| pll_pd_o | output | 1 | PLL power-down |
| osc_stby_o | output | 1 | Oscillator standby |
| reg_stby_o | output | 1 | Large regulator standby |
| osc_pd_o | output | 1 | Oscillator power-down |
| standby_o | output | 1 | Reduced-frequency Standby active |

## Verification
A table drives Wait and Stop entries with different stop-keep masks and wake sources. Some sources are allowed to wake the mode in force and some are not. This separates the Wait wake rule, where any interrupt wakes, from the Stop rule, where a peripheral wakes only if it is kept alive. It also confirms that the Stop enable vector mirrors the mask. Directed sequences walk the clock ladder with legal and skipped steps, hold Standby through Wait and Stop, and run the lock wait with the lock input both low and high. They also fire each reset kind in each mode, which separates the soft and watchdog resets from the hard reset in Power-Down.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    M_RUN  = 2'd0,
    M_WAIT = 2'd1,
    M_STOP = 2'd2,
    M_PDN  = 2'd3
  } pmc_mode_e;

  localparam int STEP_W = 3;
  localparam logic [STEP_W-1:0] STEP_PLL    = 3'd0;
  localparam logic [STEP_W-1:0] STEP_RELAX  = 3'd1;
  localparam logic [STEP_W-1:0] STEP_PLLOFF = 3'd2;
  localparam logic [STEP_W-1:0] STEP_OSCSB  = 3'd3;
  localparam logic [STEP_W-1:0] STEP_STBY   = 3'd4;
  localparam logic [STEP_W-1:0] STEP_PDN    = 3'd5;
endpackage

// File: rtl/pmc_cfg_regs.sv
module pmc_cfg_regs
  import pmc_pkg::*;
#(
  parameter int NPER = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_ok,
  input  logic [STEP_W-1:0] wr_step,
  input  logic [NPER-1:0]   wr_keep,
  output logic [STEP_W-1:0] step_q,
  output logic [STEP_W-1:0] step_d,
  output logic [NPER-1:0]   keep_q
);
  logic [NPER-1:0] keep_d;
  logic            step_legal;

  // one rung at a time, never past the power-down rung
  always_comb begin
    step_legal = (wr_step <= STEP_PDN) &&
                 ((wr_step == step_q) ||
                  (wr_step == step_q + 3'd1) ||
                  (wr_step + 3'd1 == step_q));
  end

  always_comb begin
    step_d = step_q;
    keep_d = keep_q;
    if (clr) begin
      step_d = STEP_PLL;
      keep_d = '0;
    end else if (wr_ok) begin
      keep_d = wr_keep;
      if (step_legal) step_d = wr_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= STEP_PLL;
      keep_q <= '0;
    end else begin
      step_q <= step_d;
      keep_q <= keep_d;
    end
  end
endmodule

// File: rtl/pmc_lock_timer.sv
module pmc_lock_timer #(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              pll_on,
  input  logic [LOCK_W-1:0] lock_tc,
  output logic              lock_done
);
  logic [LOCK_W-1:0] cnt_q;
  logic [LOCK_W-1:0] cnt_d;
  logic              cnt_en;

  assign lock_done = (cnt_q >= lock_tc);
  assign cnt_en    = pll_on && !lock_done;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !pll_on) cnt_d = '0;
    else if (cnt_en)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      wait_stb,
  input  logic      stop_stb,
  input  logic      wake_wait,
  input  logic      wake_stop,
  input  logic      pdn_go,
  output pmc_mode_e mode_q
);
  pmc_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (clr) begin
      mode_d = M_RUN;
    end else begin
      unique case (mode_q)
        M_RUN: begin
          if (pdn_go)        mode_d = M_PDN;
          else if (stop_stb) mode_d = M_STOP;
          else if (wait_stb) mode_d = M_WAIT;
        end
        M_WAIT:  if (wake_wait) mode_d = M_RUN;
        M_STOP:  if (wake_stop) mode_d = M_RUN;
        default: mode_d = M_PDN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_RUN;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
  import pmc_pkg::*;
#(
  parameter int NPER = 5
) (
  input  pmc_mode_e         mode,
  input  logic [NPER-1:0]   keep,
  input  logic [STEP_W-1:0] step,
  input  logic              lock_done,
  input  logic              pll_locked,
  output logic              core_en,
  output logic [NPER-1:0]   per_en,
  output logic              hs_en,
  output logic              sel_pll,
  output logic              relax,
  output logic              pll_pd,
  output logic              osc_sb,
  output logic              reg_sb,
  output logic              osc_pd,
  output logic              stby
);
  logic run_or_wait;

  assign run_or_wait = (mode == M_RUN) || (mode == M_WAIT);
  assign core_en     = (mode == M_RUN);
  assign sel_pll     = (step == STEP_PLL) && lock_done && pll_locked;
  assign hs_en       = run_or_wait && sel_pll;

  genvar g;
  generate
    for (g = 0; g < NPER; g++) begin : g_per
      assign per_en[g] = run_or_wait || ((mode == M_STOP) && keep[g]);
    end
  endgenerate

  assign relax  = (step >= STEP_RELAX);
  assign pll_pd = (step >= STEP_PLLOFF);
  assign osc_sb = (step >= STEP_OSCSB);
  assign reg_sb = (step >= STEP_STBY);
  assign osc_pd = (step == STEP_PDN);
  assign stby   = (step == STEP_STBY);
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int LOCK_W  = 8,
  localparam int NPER   = NUM_TMR + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wdog_rst,
  input  logic              wait_stb,
  input  logic              stop_stb,
  input  logic [NPER-1:0]   per_irq,
  input  logic              lvi_irq,
  input  logic              dbg_req,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_step,
  input  logic [NPER-1:0]   cfg_stop_keep,
  input  logic [LOCK_W-1:0] lock_tc,
  input  logic              pll_locked,
  output logic [1:0]        mode_o,
  output logic              core_clk_en,
  output logic [NPER-1:0]   per_clk_en,
  output logic              hs_per_clk_en,
  output logic              clk_sel_pll,
  output logic              relax_sel_o,
  output logic              pll_pd_o,
  output logic              osc_stby_o,
  output logic              reg_stby_o,
  output logic              osc_pd_o,
  output logic              standby_o
);
  pmc_mode_e         mode_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;
  logic [NPER-1:0]   keep_q;
  logic              sync_clr;
  logic              wr_ok;
  logic              wake_wait;
  logic              wake_stop;
  logic              lock_done;
  logic              pll_on;

  // the soft and watchdog resets need live logic; in power-down nothing is clocked for them
  assign sync_clr  = (soft_rst || wdog_rst) && (mode_q != M_PDN);
  assign wr_ok     = cfg_wr && (mode_q == M_RUN);
  assign wake_wait = (|per_irq) || lvi_irq || dbg_req;
  assign wake_stop = (|(per_irq & keep_q)) || lvi_irq || dbg_req;
  assign pll_on    = (step_q <= STEP_RELAX);

  pmc_cfg_regs #(.NPER(NPER)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (sync_clr),
    .wr_ok   (wr_ok),
    .wr_step (cfg_step),
    .wr_keep (cfg_stop_keep),
    .step_q  (step_q),
    .step_d  (step_d),
    .keep_q  (keep_q)
  );

  pmc_lock_timer #(.LOCK_W(LOCK_W)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sync_clr),
    .pll_on    (pll_on),
    .lock_tc   (lock_tc),
    .lock_done (lock_done)
  );

  pmc_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sync_clr),
    .wait_stb  (wait_stb),
    .stop_stb  (stop_stb),
    .wake_wait (wake_wait),
    .wake_stop (wake_stop),
    .pdn_go    (step_d == STEP_PDN),
    .mode_q    (mode_q)
  );

  pmc_clk_gate #(.NPER(NPER)) u_gate (
    .mode       (mode_q),
    .keep       (keep_q),
    .step       (step_q),
    .lock_done  (lock_done),
    .pll_locked (pll_locked),
    .core_en    (core_clk_en),
    .per_en     (per_clk_en),
    .hs_en      (hs_per_clk_en),
    .sel_pll    (clk_sel_pll),
    .relax      (relax_sel_o),
    .pll_pd     (pll_pd_o),
    .osc_sb     (osc_stby_o),
    .reg_sb     (reg_stby_o),
    .osc_pd     (osc_pd_o),
    .stby       (standby_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int NPER = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode,
  input logic            core_en,
  input logic [NPER-1:0] per_en,
  input logic [NPER-1:0] keep,
  input logic [2:0]      step,
  input logic            sel_pll,
  input logic            pll_locked,
  input logic            wake_any,
  input logic            hard_src
);
  // R2: Wait parks the core but leaves every peripheral clock running
  p_wait_gating_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (!core_en && (&per_en)));

  // R3: any wake source in Wait is back in Run one edge later
  p_wait_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd1) && wake_any) |=> (mode == 2'd0));

  // R4: in Stop only peripherals holding a stop-keep bit are clocked
  p_stop_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (!core_en && ((per_en & ~keep) == '0)));

  // R6: the ladder moves at most one rung per edge (or returns to 0 on reset)
  p_step_adjacent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step != $past(step)) |->
      ((step == $past(step) + 3'd1) || (step + 3'd1 == $past(step)) || (step == 3'd0)));

  // R7: PLL clock only with lock status and the PLL rung
  p_sel_needs_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pll |-> (pll_locked && (step == 3'd0)));

  // R9: power-down keeps everything off and is sticky
  p_pdn_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (!core_en && (per_en == '0) && hard_src));

  p_pdn_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |=> (mode == 2'd3));
endmodule

bind pmc_ctrl pmc_chk #(.NPER(NPER)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode_o),
  .core_en    (core_clk_en),
  .per_en     (per_clk_en),
  .keep       (keep_q),
  .step       (step_q),
  .sel_pll    (clk_sel_pll),
  .pll_locked (pll_locked),
  .wake_any   (wake_wait),
  .hard_src   (osc_pd_o)
);

// File: tb/sim_pmc_ctrl.sv
module sim_pmc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NPER = 5;

  logic       clk, rst_n, soft_rst, wdog_rst, wait_stb, stop_stb;
  logic [4:0] per_irq;
  logic       lvi_irq, dbg_req, cfg_wr;
  logic [2:0] cfg_step;
  logic [4:0] cfg_stop_keep;
  logic [7:0] lock_tc;
  logic       pll_locked;
  logic [1:0] mode_o;
  logic       core_clk_en;
  logic [4:0] per_clk_en;
  logic       hs_per_clk_en, clk_sel_pll, relax_sel_o, pll_pd_o;
  logic       osc_stby_o, reg_stby_o, osc_pd_o, standby_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pmc_ctrl u0 (.*);

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // vector: [13:9] stop-keep, [8] stop(1)/wait(0), [7:3] irq, [2] lvi, [1] dbg, [0] expect wake
  localparam logic [13:0] VEC [10] = '{
    {5'b00000, 1'b0, 5'b00001, 1'b0, 1'b0, 1'b1},
    {5'b00000, 1'b0, 5'b00000, 1'b1, 1'b0, 1'b1},
    {5'b00000, 1'b0, 5'b00000, 1'b0, 1'b1, 1'b1},
    {5'b00000, 1'b0, 5'b00000, 1'b0, 1'b0, 1'b0},
    {5'b00010, 1'b1, 5'b00010, 1'b0, 1'b0, 1'b1},
    {5'b00010, 1'b1, 5'b00001, 1'b0, 1'b0, 1'b0},
    {5'b10000, 1'b1, 5'b10000, 1'b0, 1'b0, 1'b1},
    {5'b00000, 1'b1, 5'b00000, 1'b1, 1'b0, 1'b1},
    {5'b00000, 1'b1, 5'b00000, 1'b0, 1'b1, 1'b1},
    {5'b01100, 1'b1, 5'b10011, 1'b0, 1'b0, 1'b0}
  };

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [4:0] k);
    cfg_wr = 1; cfg_step = s; cfg_stop_keep = k;
    tick;
    cfg_wr = 0;
  endtask

  task automatic hard_reset;
    rst_n = 0;
    tick;
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; soft_rst = 0; wdog_rst = 0; wait_stb = 0; stop_stb = 0;
    per_irq = 0; lvi_irq = 0; dbg_req = 0; cfg_wr = 0; cfg_step = 0;
    cfg_stop_keep = 0; lock_tc = 8'd10; pll_locked = 1;
    tick; tick;
    check("R1 mode in reset", mode_o, 0);
    check("R1 enables in reset", {core_clk_en, per_clk_en}, 6'h3f);
    rst_n = 1;
    tick;
    check("R1 ladder outputs", {relax_sel_o, pll_pd_o, osc_stby_o, reg_stby_o, osc_pd_o, standby_o}, 0);
    check("R7 no PLL select before lock count", clk_sel_pll, 0);
    repeat (11) tick;
    check("R7 PLL select after lock count", clk_sel_pll, 1);
    check("R7 high-speed clock in Run", hs_per_clk_en, 1);

    // table-driven Wait/Stop entries and wake sources (R2 R3 R4 R5)
    foreach (VEC[i]) begin
      wr(3'd0, VEC[i][13:9]);
      if (VEC[i][8]) stop_stb = 1; else wait_stb = 1;
      tick;
      stop_stb = 0; wait_stb = 0;
      if (VEC[i][8]) begin
        check("R4 Stop entered", mode_o, 2);
        check("R4 Stop enables", {core_clk_en, per_clk_en}, {1'b0, VEC[i][13:9]});
      end else begin
        check("R2 Wait entered", mode_o, 1);
        check("R2 Wait enables", {core_clk_en, per_clk_en}, 6'h1f);
      end
      per_irq = VEC[i][7:3]; lvi_irq = VEC[i][2]; dbg_req = VEC[i][1];
      tick;
      per_irq = 0; lvi_irq = 0; dbg_req = 0;
      check(VEC[i][8] ? "R5 Stop wake rule" : "R3 Wait wake rule",
            mode_o, VEC[i][0] ? 0 : (VEC[i][8] ? 2 : 1));
      if (!VEC[i][0]) begin
        dbg_req = 1; tick; dbg_req = 0;
        check("R3 debug wake", mode_o, 0);
      end
    end

    // R4 priority
    wr(3'd0, 5'b00000);
    wait_stb = 1; stop_stb = 1; tick; wait_stb = 0; stop_stb = 0;
    check("R4 Stop beats Wait", mode_o, 2);
    dbg_req = 1; tick; dbg_req = 0;

    // R6 ladder
    wr(3'd2, 0);
    check("R6 skipped rung ignored", relax_sel_o, 0);
    wr(3'd1, 0);
    check("R6 rung 1", {relax_sel_o, pll_pd_o}, 2'b10);
    check("R7 no PLL select on relax clock", clk_sel_pll, 0);
    wr(3'd2, 0);
    wr(3'd4, 0);
    check("R6 jump to 4 ignored", {pll_pd_o, osc_stby_o}, 2'b10);
    wr(3'd3, 0);
    wr(3'd4, 0);
    check("R6 standby reached", {osc_stby_o, reg_stby_o, standby_o}, 3'b111);
    check("R7 no high-speed clock in standby", hs_per_clk_en, 0);

    // R8 / R11 standby held through Wait and Stop
    wait_stb = 1; tick; wait_stb = 0;
    wr(3'd3, 0);
    check("R8 write in Wait ignored", {mode_o, standby_o}, 3'b011);
    per_irq = 5'b00100; tick; per_irq = 0;
    check("R3 wake from Wait in standby", mode_o, 0);
    stop_stb = 1; tick; stop_stb = 0;
    wait_stb = 1; tick; wait_stb = 0;
    check("R11 wait strobe ignored in Stop", mode_o, 2);
    check("R8 standby held in Stop", standby_o, 1);
    dbg_req = 1; tick; dbg_req = 0;

    // R7 return to PLL
    wr(3'd3, 0); wr(3'd2, 0); wr(3'd1, 0);
    pll_locked = 0;
    wr(3'd0, 0);
    check("R7 select waits for counter", clk_sel_pll, 0);
    repeat (15) tick;
    check("R7 select waits for lock status", clk_sel_pll, 0);
    pll_locked = 1; #1;
    check("R7 select after lock status", clk_sel_pll, 1);

    // R10 soft and watchdog resets
    wr(3'd1, 5'b00011);
    stop_stb = 1; tick; stop_stb = 0;
    soft_rst = 1; tick; soft_rst = 0;
    check("R10 soft reset from Stop", {mode_o, relax_sel_o}, 0);
    stop_stb = 1; tick; stop_stb = 0;
    check("R10 stop-keep bits cleared", per_clk_en, 0);
    dbg_req = 1; tick; dbg_req = 0;
    wr(3'd1, 0);
    wait_stb = 1; tick; wait_stb = 0;
    wdog_rst = 1; tick; wdog_rst = 0;
    check("R10 watchdog reset from Wait", {mode_o, relax_sel_o}, 0);

    // R9 power-down
    wr(3'd1, 5'b11111); wr(3'd2, 5'b11111); wr(3'd3, 5'b11111); wr(3'd4, 5'b11111);
    wr(3'd5, 5'b11111);
    check("R9 power-down entered", {mode_o, osc_pd_o}, 3'b111);
    check("R9 all clocks off", {core_clk_en, per_clk_en, hs_per_clk_en}, 0);
    per_irq = 5'b11111; lvi_irq = 1; dbg_req = 1; soft_rst = 1; wdog_rst = 1; wait_stb = 1;
    tick; tick;
    per_irq = 0; lvi_irq = 0; dbg_req = 0; soft_rst = 0; wdog_rst = 0; wait_stb = 0;
    check("R9 wakes and soft resets ignored", {mode_o, osc_pd_o}, 3'b111);
    hard_reset;
    check("R9 hard reset exits", {mode_o, osc_pd_o, core_clk_en}, 3'b001);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule